// File: doc/BRIEF.md
# Processor Power Mode Controller

This block is the mode sequencer for a processor's power management. It keeps track of which of five operating modes the processor is in. It turns that mode into four registered controls: a core clock enable, a system clock enable, a PLL enable and a PLL bypass select. When hibernate is entered it raises a request line to a separate regulator controller. Actual clock generation, PLL lock timing, voltage regulation and DMA arbitration are handled elsewhere.

Software drives the block through two inputs. One is a configuration write that stores a PLL-enable bit and a bypass bit. The other is a one-cycle mode request carrying a 3-bit target code. A request that breaks the transition rules is dropped, and an error output pulses for one cycle. Two events leave the low-power modes:
- An enabled wake-up event exits SLEEP. The destination depends on the stored bypass bit.
- An asynchronous RTC interrupt, synchronised on the always-running clock, exits DEEP_SLEEP into ACTIVE.

Reset returns every mode to FULL_ON.

States and their encodings: FULL_ON=0, ACTIVE=1, SLEEP=2, DEEP_SLEEP=3, HIBERNATE=4. Codes 5 to 7 are not modes.

Transitions:
- GO_ACTIVE: FULL_ON to ACTIVE.
- GO_FULL: ACTIVE to FULL_ON.
- GO_SLEEP: FULL_ON or ACTIVE to SLEEP.
- GO_DEEP: FULL_ON or ACTIVE to DEEP_SLEEP.
- GO_HIBER: FULL_ON or ACTIVE to HIBERNATE.
- WAKE_FULL and WAKE_BYP: SLEEP to FULL_ON or ACTIVE.
- RTC_EXIT: DEEP_SLEEP to ACTIVE.
- RESET_EXIT: any mode to FULL_ON.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While reset is held and after it is released, `mode` is 0 (FULL_ON), `cclk_en`, `sclk_en` and `pll_en` are 1, and `pll_bypass`, `hib_req` and `req_err` are 0. The stored PLL-enable bit resets to 1 and the stored bypass bit resets to 0.
- R2: The outputs follow the mode (cclk_en/sclk_en/pll_en/pll_bypass/hib_req):
  - FULL_ON gives 1/1/1/0/0.
  - ACTIVE gives 1/1/stored PLL-enable/1/0.
  - SLEEP gives 0/1/1/stored bypass/0.
  - DEEP_SLEEP gives 0/0/0/1/0.
  - HIBERNATE gives 0/0/0/1/1.
- R3: From FULL_ON, a request with code 1, 2, 3 or 4 moves the block to that mode. The new `mode` and outputs appear at the first clock edge that samples the strobe.
- R4: From ACTIVE, requests for FULL_ON (0) or SLEEP (2) are taken only when the stored PLL-enable bit is 1. Requests for DEEP_SLEEP (3) and HIBERNATE (4) are always taken.
- R5: A refused request leaves `mode` unchanged and raises `req_err` for the one cycle after the strobe. Refused requests are:
  - codes 5 to 7;
  - a request for the current mode;
  - any request while in SLEEP, DEEP_SLEEP or HIBERNATE;
  - a request blocked by R4.
- R6: In SLEEP, `wake_evt` moves the block to ACTIVE when the stored bypass bit is 1, and to FULL_ON when it is 0. In every other mode `wake_evt` has no effect.
- R7: DEEP_SLEEP is left only by reset or by the RTC interrupt. A rising `rtc_irq_async` applied between edges gives ACTIVE at the third clock edge after it. `wake_evt` has no effect in DEEP_SLEEP.
- R8: HIBERNATE raises `hib_req` and is left only by reset. Neither `wake_evt` nor the RTC interrupt moves it.
- R9: A configuration write updates the stored bits only in FULL_ON and ACTIVE. In SLEEP, DEEP_SLEEP and HIBERNATE the write is ignored.
- R10: When a request and a configuration write arrive in the same cycle, the request is judged on the stored PLL-enable bit as it was before that write.
- R11: `cclk_en` and `sclk_en` change only in a cycle where `mode` changes.
- R12: Asserting `rst_n` low in any mode returns the outputs to the FULL_ON values at once, without waiting for a clock edge, and restores the stored bits to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pll_en | input | 1 | PLL-enable value to store |
| cfg_pll_byp | input | 1 | Bypass value to store |
| req_vld | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake_evt | input | 1 | Enabled wake-up event (synchronous) |
| rtc_irq_async | input | 1 | Asynchronous RTC interrupt |
| mode | output | 3 | Current mode code |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | PLL bypass select |
| hib_req | output | 1 | Hibernate request to the regulator controller |
| req_err | output | 1 | Refused-request pulse |

## Verification
A mode request and a configuration write can land on the same clock edge. The write may clear or set the very PLL-enable bit that the request's legality depends on. The bench starts in ACTIVE with the PLL-enable bit cleared. In one cycle it sends a request for FULL_ON together with a write that sets the bit. It expects the request to be refused with an error pulse, and the `pll_en` output to show the newly written value at the same edge. A follow-up request for FULL_ON is then expected to succeed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_FULLON = 3'd0,
        MD_ACTIVE = 3'd1,
        MD_SLEEP  = 3'd2,
        MD_DEEP   = 3'd3,
        MD_HIBER  = 3'd4
    } pmode_e;

    typedef struct packed {
        logic cclk_en;
        logic sclk_en;
        logic pll_en;
        logic pll_byp;
        logic hib_req;
    } pout_s;

    localparam pout_s OUT_RESET = '{cclk_en: 1'b1, sclk_en: 1'b1, pll_en: 1'b1,
                                    pll_byp: 1'b0, hib_req: 1'b0};
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_rules.sv
module pmc_rules
    import pmc_pkg::*;
(
    input  pmode_e               cur,
    input  logic                 req_vld,
    input  logic [MODE_W-1:0]    req_code,
    input  logic                 pll_en_q,
    input  logic                 byp_q,
    input  logic                 wake,
    input  logic                 rtc_s,
    output pmode_e               nxt,
    output logic                 refuse
);
    always_comb begin
        nxt    = cur;
        refuse = 1'b0;
        unique case (cur)
            MD_FULLON: begin
                if (req_vld) begin
                    case (req_code)
                        3'd1, 3'd2, 3'd3, 3'd4: nxt = pmode_e'(req_code);
                        default:                refuse = 1'b1;
                    endcase
                end
            end
            MD_ACTIVE: begin
                if (req_vld) begin
                    case (req_code)
                        3'd0, 3'd2: begin
                            if (pll_en_q) nxt = pmode_e'(req_code);
                            else          refuse = 1'b1;
                        end
                        3'd3, 3'd4: nxt = pmode_e'(req_code);
                        default:    refuse = 1'b1;
                    endcase
                end
            end
            MD_SLEEP: begin
                refuse = req_vld;
                if (wake) nxt = byp_q ? MD_ACTIVE : MD_FULLON;
            end
            MD_DEEP: begin
                refuse = req_vld;
                if (rtc_s) nxt = MD_ACTIVE;
            end
            MD_HIBER: begin
                refuse = req_vld;
            end
        endcase
    end
endmodule

// File: rtl/pmc_out_map.sv
module pmc_out_map
    import pmc_pkg::*;
(
    input  pmode_e md,
    input  logic   pll_en_cfg,
    input  logic   byp_cfg,
    output pout_s  o
);
    always_comb begin
        o = OUT_RESET;
        unique case (md)
            MD_FULLON: o = '{cclk_en: 1'b1, sclk_en: 1'b1, pll_en: 1'b1,
                             pll_byp: 1'b0, hib_req: 1'b0};
            MD_ACTIVE: o = '{cclk_en: 1'b1, sclk_en: 1'b1, pll_en: pll_en_cfg,
                             pll_byp: 1'b1, hib_req: 1'b0};
            MD_SLEEP:  o = '{cclk_en: 1'b0, sclk_en: 1'b1, pll_en: 1'b1,
                             pll_byp: byp_cfg, hib_req: 1'b0};
            MD_DEEP:   o = '{cclk_en: 1'b0, sclk_en: 1'b0, pll_en: 1'b0,
                             pll_byp: 1'b1, hib_req: 1'b0};
            MD_HIBER:  o = '{cclk_en: 1'b0, sclk_en: 1'b0, pll_en: 1'b0,
                             pll_byp: 1'b1, hib_req: 1'b1};
        endcase
    end
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_pll_en,
    input  logic              cfg_pll_byp,
    input  logic              req_vld,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              wake_evt,
    input  logic              rtc_irq_async,
    output logic [MODE_W-1:0] mode,
    output logic              cclk_en,
    output logic              sclk_en,
    output logic              pll_en,
    output logic              pll_bypass,
    output logic              hib_req,
    output logic              req_err
);
    pmode_e state_q, state_d;
    logic   pll_en_q, byp_q, pll_en_d, byp_d;
    logic   cfg_ok, refuse, rtc_s;
    pout_s  out_d, out_q;
    logic   err_q;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rtc_irq_async),
        .q     (rtc_s)
    );

    // Legality is judged on the stored bits before any write of this cycle.
    pmc_rules u_rules (
        .cur      (state_q),
        .req_vld  (req_vld),
        .req_code (req_mode),
        .pll_en_q (pll_en_q),
        .byp_q    (byp_q),
        .wake     (wake_evt),
        .rtc_s    (rtc_s),
        .nxt      (state_d),
        .refuse   (refuse)
    );

    assign cfg_ok   = cfg_we && (state_q == MD_FULLON || state_q == MD_ACTIVE);
    assign pll_en_d = cfg_ok ? cfg_pll_en  : pll_en_q;
    assign byp_d    = cfg_ok ? cfg_pll_byp : byp_q;

    pmc_out_map u_map (
        .md         (state_d),
        .pll_en_cfg (pll_en_d),
        .byp_cfg    (byp_d),
        .o          (out_d)
    );

    // State and stored configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MD_FULLON;
            pll_en_q <= 1'b1;
            byp_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            pll_en_q <= pll_en_d;
            byp_q    <= byp_d;
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RESET;
            err_q <= 1'b0;
        end else begin
            out_q <= out_d;
            err_q <= refuse;
        end
    end

    assign mode       = state_q;
    assign cclk_en    = out_q.cclk_en;
    assign sclk_en    = out_q.sclk_en;
    assign pll_en     = out_q.pll_en;
    assign pll_bypass = out_q.pll_byp;
    assign hib_req    = out_q.hib_req;
    assign req_err    = err_q;

    AST_FULLON_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_FULLON) |-> (cclk_en && sclk_en && pll_en && !pll_bypass && !hib_req)); // R2
    AST_ACTIVE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_ACTIVE && !pll_en_q) |=> (state_q != MD_FULLON && state_q != MD_SLEEP)); // R4
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (state_q == $past(state_q))); // R5
    AST_SLEEP_WAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_SLEEP && wake_evt && !byp_q) |=> (state_q == MD_FULLON)); // R6
    AST_DEEP_EXIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_DEEP) |=> (state_q == MD_DEEP || state_q == MD_ACTIVE)); // R7
    AST_HIBER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_HIBER) |=> (state_q == MD_HIBER && hib_req)); // R8
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_SLEEP || state_q == MD_DEEP || state_q == MD_HIBER)
        |=> ($stable(pll_en_q) && $stable(byp_q))); // R9
    AST_CLK_EN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q) |-> ($stable(cclk_en) && $stable(sclk_en))); // R11
endmodule

// File: tb/tb_pmc_power_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_power_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we, cfg_pll_en, cfg_pll_byp, req_vld, wake_evt, rtc;
    logic [2:0] req_mode;
    logic [2:0] mode;
    logic       cclk_en, sclk_en, pll_en, pll_bypass, hib_req, req_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic epe, eby;   // expected stored configuration

    typedef struct {
        logic [2:0] md;
        logic       err;
        logic [4:0] outs;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    pmc_power_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pll_en(cfg_pll_en),
        .cfg_pll_byp(cfg_pll_byp), .req_vld(req_vld), .req_mode(req_mode),
        .wake_evt(wake_evt), .rtc_irq_async(rtc), .mode(mode), .cclk_en(cclk_en),
        .sclk_en(sclk_en), .pll_en(pll_en), .pll_bypass(pll_bypass),
        .hib_req(hib_req), .req_err(req_err)
    );

    // R2 output table: {cclk, sclk, pll_en, bypass, hib}
    function automatic logic [4:0] exp_outs(input logic [2:0] m, input logic pe, input logic by);
        case (m)
            3'd0:    return 5'b11100;
            3'd1:    return {2'b11, pe, 2'b10};
            3'd2:    return {3'b011, by, 1'b0};
            3'd3:    return 5'b00010;
            default: return 5'b00011;
        endcase
    endfunction

    task automatic compare(input logic [2:0] em, input logic ee, input logic [4:0] eo, input string tag);
        logic [4:0] got;
        got = {cclk_en, sclk_en, pll_en, pll_bypass, hib_req};
        total++;
        if (mode !== em || req_err !== ee || got !== eo) begin
            bad++;
            $display("FAIL %s: got mode=%0d err=%b outs=%b exp mode=%0d err=%b outs=%b",
                     tag, mode, req_err, got, em, ee, eo);
        end
    endtask

    // Monitor: pops the expected item after each driven edge.
    always @(negedge clk) begin : mon
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            compare(e.md, e.err, e.outs, e.tag);
        end
    end

    // Driver: called at a falling edge, applies one cycle of stimulus.
    task automatic step(input logic rv, input logic [2:0] rm, input logic we,
                        input logic wpe, input logic wby, input logic wk,
                        input logic [2:0] em, input logic ee, input string tag);
        exp_t e;
        req_vld = rv; req_mode = rm; cfg_we = we; cfg_pll_en = wpe;
        cfg_pll_byp = wby; wake_evt = wk;
        @(posedge clk);
        e.md = em; e.err = ee; e.outs = exp_outs(em, epe, eby); e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_vld = 1'b0; cfg_we = 1'b0; wake_evt = 1'b0;
    endtask

    task automatic idle(input logic [2:0] em, input string tag);
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, em, 1'b0, tag);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : drv
        rst_n = 1'b0; cfg_we = 0; cfg_pll_en = 0; cfg_pll_byp = 0;
        req_vld = 0; req_mode = 0; wake_evt = 0; rtc = 0;
        epe = 1'b1; eby = 1'b0;
        repeat (3) @(negedge clk);
        compare(3'd0, 1'b0, 5'b11100, "R1 in reset");
        rst_n = 1'b1;
        idle(3'd0, "R1 after release");
        step(1, 3'd5, 0, 0, 0, 0, 3'd0, 1, "R5 code 5");
        step(1, 3'd7, 0, 0, 0, 0, 3'd0, 1, "R5 code 7");
        step(1, 3'd0, 0, 0, 0, 0, 3'd0, 1, "R5 same mode");
        epe = 0; eby = 1;
        step(0, 3'd0, 1, 0, 1, 0, 3'd0, 0, "R9 R11 write in full-on");
        step(1, 3'd1, 0, 0, 0, 0, 3'd1, 0, "R3 go active");
        step(1, 3'd0, 0, 0, 0, 0, 3'd1, 1, "R4 full-on refused");
        step(1, 3'd2, 0, 0, 0, 0, 3'd1, 1, "R4 sleep refused");
        epe = 1;
        step(1, 3'd0, 1, 1, 1, 0, 3'd1, 1, "R10 request with write");
        step(1, 3'd0, 0, 0, 0, 0, 3'd0, 0, "R4 full-on granted");
        step(1, 3'd2, 0, 0, 0, 0, 3'd2, 0, "R3 go sleep");
        step(1, 3'd1, 0, 0, 0, 0, 3'd2, 1, "R5 request in sleep");
        step(0, 3'd0, 1, 0, 0, 0, 3'd2, 0, "R9 write ignored in sleep");
        step(0, 3'd0, 0, 0, 0, 1, 3'd1, 0, "R6 wake to active");
        eby = 0;
        step(0, 3'd0, 1, 1, 0, 0, 3'd1, 0, "R9 write in active");
        step(1, 3'd2, 0, 0, 0, 0, 3'd2, 0, "R4 sleep granted");
        step(0, 3'd0, 0, 0, 0, 1, 3'd0, 0, "R6 wake to full-on");
        step(0, 3'd0, 0, 0, 0, 1, 3'd0, 0, "R6 wake ignored in full-on");
        step(1, 3'd3, 0, 0, 0, 0, 3'd3, 0, "R3 go deep");
        step(0, 3'd0, 0, 0, 0, 1, 3'd3, 0, "R7 wake ignored in deep");
        step(1, 3'd0, 0, 0, 0, 0, 3'd3, 1, "R5 request in deep");
        rtc = 1'b1;
        idle(3'd3, "R7 rtc edge 1");
        idle(3'd3, "R7 rtc edge 2");
        idle(3'd1, "R7 rtc edge 3");
        rtc = 1'b0;
        step(1, 3'd4, 0, 0, 0, 0, 3'd4, 0, "R3 R8 go hibernate");
        step(0, 3'd0, 0, 0, 0, 1, 3'd4, 0, "R8 wake ignored");
        rtc = 1'b1;
        idle(3'd4, "R8 rtc 1");
        idle(3'd4, "R8 rtc 2");
        idle(3'd4, "R8 rtc 3");
        rtc = 1'b0;
        step(1, 3'd0, 0, 0, 0, 0, 3'd4, 1, "R8 request in hibernate");
        rst_n = 1'b0;
        #1;
        compare(3'd0, 1'b0, 5'b11100, "R12 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        epe = 1; eby = 0;
        step(1, 3'd1, 0, 0, 0, 0, 3'd1, 0, "R12 stored bits restored");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule